// File: doc/BRIEF.md
# Stride-2 Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to a next-hop code by walking a four-way trie kept in an on-block node table. Each table entry holds four child indices, one for each value of a 2-bit address slice, plus an optional next-hop code. The code is present only when a stored route ends at that node. The walk starts at entry 0, which is the root. On each clock it reads one node and uses the next two address bits, taken from the most significant end, to pick the child it visits next.

While it walks, the engine keeps the most recent next-hop code it has passed. That code is the longest matching route. The walk stops at a null child index or once all 32 bits have been consumed, and the engine then reports the kept code. Routes whose length is odd are stored before lookup as two sibling copies at the next even depth. The table is filled through a write port by whoever compiles the routes.

Requests use a valid/ready handshake. The result is announced by a one-cycle done pulse, and the next-hop and found outputs hold their value until the next lookup completes.

Top module: `trie_lookup`

## Requirements
- R1: While reset is held and after it is released, in_ready_o is 1 and done_o, found_o and next_hop_o are 0.
- R2: A lookup is accepted on a clock edge where in_valid_i and in_ready_o are both 1. in_ready_o is 0 from the cycle after acceptance until done_o has been high. in_valid_i and in_addr_i are ignored while in_ready_o is 0, so the result belongs to the accepted address.
- R3: Address bits are consumed two per level, starting at bits [31:30]. The 2-bit value v selects child field v, which sits at mem_child_i bits [6v+5:6v] of the written entry.
- R4: A child index of 0 is null and ends the walk at the current node. The root is entry 0.
- R5: The reported next-hop is the code of the deepest node on the path whose next-hop flag is set, so a longer route overrides a shorter one. A route of odd length is matched through its two sibling copies.
- R6: If no node on the path has its next-hop flag set, found_o is 0 and next_hop_o is 0.
- R7: The walk reads one node per cycle. If it visits n nodes, done_o is high for exactly one cycle, the (n+1)th cycle after the acceptance edge, and in_ready_o returns to 1 in the cycle after that.
- R8: After 16 steps the whole address has been consumed. The 17th node is still examined for a next-hop code and the walk stops there, so at most 17 nodes are visited.
- R9: found_o and next_hop_o change only in a cycle where done_o is 1.
- R10: An entry written with mem_we_i takes effect for every lookup accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Lookup request valid |
| in_ready_o | output | 1 | Engine idle, request can be accepted |
| in_addr_i | input | 32 | Address to resolve |
| mem_we_i | input | 1 | Node table write strobe |
| mem_idx_i | input | 6 | Node table entry to write |
| mem_child_i | input | 24 | Four child indices, field v at bits [6v+5:6v] |
| mem_nh_vld_i | input | 1 | A route ends at this node |
| mem_nh_i | input | 8 | Next-hop code of this node |
| done_o | output | 1 | One-cycle pulse: result is ready |
| found_o | output | 1 | A matching route was found |
| next_hop_o | output | 8 | Next-hop code, 0 if none found |

## Verification
The checker watches the handshake and result timing on every cycle. It confirms that acceptance drops in_ready_o, that done_o lasts exactly one cycle and hands back to idle, and that the outputs stay stable outside done. It also confirms that a miss always reports code 0 and that no walk occupies the engine for longer than 17 node reads plus the done cycle. Whether the right child was followed, and whether the deepest next-hop wins over a shallower one, depends on the table contents. Only the bench scenarios can show that: they compare each result and its exact done cycle against a behavioural walk over the same table. Those scenarios cover nested routes, an expanded odd-length route, misses, a full 32-bit path, requests ignored while busy and a rewritten entry.

// File: rtl/trie_pkg.sv
package trie_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned STRIDE_DEF = 2;
  localparam int unsigned PTR_W_DEF  = 6;
  localparam int unsigned NH_W_DEF   = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
  parameter int unsigned PTR_W  = 6,
  parameter int unsigned FANOUT = 4,
  parameter int unsigned NH_W   = 8,
  localparam int unsigned DEPTH = 1 << PTR_W,
  localparam int unsigned CH_W  = FANOUT * PTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [CH_W-1:0]  wr_child_i,
  input  logic             wr_nh_vld_i,
  input  logic [NH_W-1:0]  wr_nh_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [CH_W-1:0]  rd_child_o,
  output logic             rd_nh_vld_o,
  output logic [NH_W-1:0]  rd_nh_o
);
  logic [CH_W-1:0] child_q [DEPTH];
  logic [DEPTH-1:0] nh_vld_q;
  logic [NH_W-1:0] nh_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        child_q[i] <= '0;
        nh_q[i]    <= '0;
      end
      nh_vld_q <= '0;
    end else if (we_i) begin
      child_q[wr_idx_i]  <= wr_child_i;
      nh_vld_q[wr_idx_i] <= wr_nh_vld_i;
      nh_q[wr_idx_i]     <= wr_nh_i;
    end
  end

  assign rd_child_o  = child_q[rd_idx_i];
  assign rd_nh_vld_o = nh_vld_q[rd_idx_i];
  assign rd_nh_o     = nh_q[rd_idx_i];
endmodule

// File: rtl/trie_step.sv
// One level of the walk: fold in the node's next-hop, pick the child.
module trie_step #(
  parameter int unsigned STRIDE = 2,
  parameter int unsigned PTR_W  = 6,
  parameter int unsigned NH_W   = 8,
  parameter int unsigned LEVELS = 16,
  localparam int unsigned FANOUT = 1 << STRIDE,
  localparam int unsigned CH_W   = FANOUT * PTR_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic [STRIDE-1:0] slice_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [CH_W-1:0]   child_i,
  input  logic              nh_vld_i,
  input  logic [NH_W-1:0]   nh_i,
  input  logic              best_vld_i,
  input  logic [NH_W-1:0]   best_nh_i,
  output logic              best_vld_o,
  output logic [NH_W-1:0]   best_nh_o,
  output logic [PTR_W-1:0]  next_idx_o,
  output logic              stop_o
);
  logic [PTR_W-1:0] slot_ptr [FANOUT];
  logic             last_lvl;

  for (genvar s = 0; s < int'(FANOUT); s++) begin : g_slot
    assign slot_ptr[s] = child_i[s*PTR_W +: PTR_W];
  end

  assign last_lvl   = (level_i == LVL_W'(LEVELS));
  assign next_idx_o = slot_ptr[slice_i];
  assign stop_o     = last_lvl || (next_idx_o == '0);

  always_comb begin
    best_vld_o = best_vld_i;
    best_nh_o  = best_nh_i;
    if (nh_vld_i) begin
      best_vld_o = 1'b1;
      best_nh_o  = nh_i;
    end
  end
endmodule

// File: rtl/trie_walk_ctrl.sv
module trie_walk_ctrl
  import trie_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRIDE = 2,
  parameter int unsigned PTR_W  = 6,
  parameter int unsigned NH_W   = 8,
  localparam int unsigned LEVELS = ADDR_W / STRIDE,
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic [PTR_W-1:0]  rd_idx_o,
  output logic [STRIDE-1:0] slice_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              best_vld_o,
  output logic [NH_W-1:0]   best_nh_o,
  input  logic              step_best_vld_i,
  input  logic [NH_W-1:0]   step_best_nh_i,
  input  logic [PTR_W-1:0]  step_next_i,
  input  logic              step_stop_i,
  output logic              done_o,
  output logic              found_o,
  output logic [NH_W-1:0]   next_hop_o
);
  walk_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  idx_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              best_vld_q;
  logic [NH_W-1:0]   best_nh_q;
  logic              found_q;
  logic [NH_W-1:0]   nh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      idx_q      <= '0;
      lvl_q      <= '0;
      best_vld_q <= 1'b0;
      best_nh_q  <= '0;
      found_q    <= 1'b0;
      nh_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid_i) begin
            addr_q     <= in_addr_i;
            idx_q      <= '0;
            lvl_q      <= '0;
            best_vld_q <= 1'b0;
            best_nh_q  <= '0;
            state_q    <= ST_WALK;
          end
        end
        ST_WALK: begin
          best_vld_q <= step_best_vld_i;
          best_nh_q  <= step_best_nh_i;
          if (step_stop_i) begin
            found_q <= step_best_vld_i;
            nh_q    <= step_best_vld_i ? step_best_nh_i : '0;
            state_q <= ST_DONE;
          end else begin
            idx_q  <= step_next_i;
            lvl_q  <= lvl_q + 1'b1;
            addr_q <= addr_q << STRIDE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o = (state_q == ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign rd_idx_o   = idx_q;
  assign slice_o    = addr_q[ADDR_W-1 -: STRIDE];
  assign level_o    = lvl_q;
  assign best_vld_o = best_vld_q;
  assign best_nh_o  = best_nh_q;
  assign found_o    = found_q;
  assign next_hop_o = nh_q;
endmodule

// File: rtl/trie_lookup.sv
module trie_lookup
  import trie_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned STRIDE = STRIDE_DEF,
  parameter int unsigned PTR_W  = PTR_W_DEF,
  parameter int unsigned NH_W   = NH_W_DEF,
  localparam int unsigned FANOUT = 1 << STRIDE,
  localparam int unsigned CH_W   = FANOUT * PTR_W,
  localparam int unsigned LEVELS = ADDR_W / STRIDE,
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic              mem_we_i,
  input  logic [PTR_W-1:0]  mem_idx_i,
  input  logic [CH_W-1:0]   mem_child_i,
  input  logic              mem_nh_vld_i,
  input  logic [NH_W-1:0]   mem_nh_i,
  output logic              done_o,
  output logic              found_o,
  output logic [NH_W-1:0]   next_hop_o
);
  logic [PTR_W-1:0]  rd_idx;
  logic [CH_W-1:0]   rd_child;
  logic              rd_nh_vld;
  logic [NH_W-1:0]   rd_nh;
  logic [STRIDE-1:0] slice;
  logic [LVL_W-1:0]  level;
  logic              best_vld, step_best_vld, step_stop;
  logic [NH_W-1:0]   best_nh, step_best_nh;
  logic [PTR_W-1:0]  step_next;

  trie_node_mem #(.PTR_W(PTR_W), .FANOUT(FANOUT), .NH_W(NH_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (mem_we_i),
    .wr_idx_i    (mem_idx_i),
    .wr_child_i  (mem_child_i),
    .wr_nh_vld_i (mem_nh_vld_i),
    .wr_nh_i     (mem_nh_i),
    .rd_idx_i    (rd_idx),
    .rd_child_o  (rd_child),
    .rd_nh_vld_o (rd_nh_vld),
    .rd_nh_o     (rd_nh)
  );

  trie_step #(.STRIDE(STRIDE), .PTR_W(PTR_W), .NH_W(NH_W), .LEVELS(LEVELS)) u_step (
    .slice_i    (slice),
    .level_i    (level),
    .child_i    (rd_child),
    .nh_vld_i   (rd_nh_vld),
    .nh_i       (rd_nh),
    .best_vld_i (best_vld),
    .best_nh_i  (best_nh),
    .best_vld_o (step_best_vld),
    .best_nh_o  (step_best_nh),
    .next_idx_o (step_next),
    .stop_o     (step_stop)
  );

  trie_walk_ctrl #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .PTR_W(PTR_W), .NH_W(NH_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .in_valid_i      (in_valid_i),
    .in_ready_o      (in_ready_o),
    .in_addr_i       (in_addr_i),
    .rd_idx_o        (rd_idx),
    .slice_o         (slice),
    .level_o         (level),
    .best_vld_o      (best_vld),
    .best_nh_o       (best_nh),
    .step_best_vld_i (step_best_vld),
    .step_best_nh_i  (step_best_nh),
    .step_next_i     (step_next),
    .step_stop_i     (step_stop),
    .done_o          (done_o),
    .found_o         (found_o),
    .next_hop_o      (next_hop_o)
  );
endmodule

// File: rtl/trie_lookup_chk.sv
module trie_lookup_chk #(
  parameter int unsigned LEVELS = 16,
  parameter int unsigned NH_W   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            done_o,
  input logic            found_o,
  input logic [NH_W-1:0] next_hop_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_cnt <= 0;
    else if (in_ready_o) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && !done_o));

  assert_done_not_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !in_ready_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && in_ready_o));

  assert_walk_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (busy_cnt <= LEVELS + 1));

  assert_miss_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (next_hop_o == '0));

  assert_hold_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(next_hop_o) && $stable(found_o)));
endmodule

bind trie_lookup trie_lookup_chk #(.LEVELS(LEVELS), .NH_W(NH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .done_o     (done_o),
  .found_o    (found_o),
  .next_hop_o (next_hop_o)
);

// File: tb/trie_lookup_test.sv
`timescale 1ns/1ps
module trie_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        mem_we = 1'b0;
  logic [5:0]  mem_idx = '0;
  logic [23:0] mem_child = '0;
  logic        mem_nh_vld = 1'b0;
  logic [7:0]  mem_nh = '0;
  logic        done, found;
  logic [7:0]  next_hop;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model of the table
  int m_ch  [64][4];
  bit m_nhv [64];
  int m_nh  [64];
  int last_nh = 0;
  bit last_found = 0;

  always #4 clk = ~clk;

  trie_lookup uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .mem_we_i(mem_we), .mem_idx_i(mem_idx),
    .mem_child_i(mem_child), .mem_nh_vld_i(mem_nh_vld), .mem_nh_i(mem_nh),
    .done_o(done), .found_o(found), .next_hop_o(next_hop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_node(input int idx, input int c0, input int c1, input int c2,
                         input int c3, input bit hv, input int hop);
    @(negedge clk);
    mem_we = 1'b1; mem_idx = 6'(idx);
    mem_child = {6'(c3), 6'(c2), 6'(c1), 6'(c0)};
    mem_nh_vld = hv; mem_nh = 8'(hop);
    m_ch[idx][0] = c0; m_ch[idx][1] = c1; m_ch[idx][2] = c2; m_ch[idx][3] = c3;
    m_nhv[idx] = hv; m_nh[idx] = hop;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic model_walk(input logic [31:0] a, output int hop, output bit fnd,
                            output int visits);
    int idx = 0;
    hop = 0; fnd = 0; visits = 0;
    for (int lvl = 0; lvl <= 16; lvl++) begin
      visits++;
      if (m_nhv[idx]) begin fnd = 1; hop = m_nh[idx]; end
      if (lvl == 16) break;
      begin
        int slot = int'((a >> (30 - 2*lvl)) & 32'h3);
        if (m_ch[idx][slot] == 0) break;
        idx = m_ch[idx][slot];
      end
    end
  endtask

  // distract: keep in_valid high with another address while busy (R2)
  task automatic lookup(input logic [31:0] a, input bit distract, input logic [31:0] other);
    int e_hop, e_vis;
    bit e_fnd;
    model_walk(a, e_hop, e_fnd, e_vis);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before request", int'(in_ready), 1);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    if (distract) in_addr = other; else in_valid = 1'b0;
    for (int c = 1; c <= e_vis + 1; c++) begin
      if (c > 1) @(negedge clk);
      if (c == e_vis + 1) in_valid = 1'b0;
      check(done == (c == e_vis + 1), "R7 done timing", int'(done), int'(c == e_vis + 1));
      check(in_ready == 1'b0, "R2 busy while walking", int'(in_ready), 0);
      if (c <= e_vis) begin
        check(next_hop == 8'(last_nh) && found == last_found, "R9 result held",
              int'(next_hop), last_nh);
      end else begin
        check(found == e_fnd, "R5 R6 found flag", int'(found), int'(e_fnd));
        check(next_hop == 8'(e_hop), "R3 R5 next-hop", int'(next_hop), e_hop);
        if (!e_fnd) check(next_hop == 8'd0, "R6 default hop", int'(next_hop), 0);
      end
    end
    @(negedge clk);
    check(done == 1'b0 && in_ready == 1'b1, "R7 back to idle", int'(in_ready), 1);
    last_nh = e_hop; last_found = e_fnd;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 4; s++) m_ch[i][s] = 0;
      m_nhv[i] = 0; m_nh[i] = 0;
    end
    #20;
    check(in_ready == 1'b1 && done == 1'b0, "R1 reset handshake", int'(done), 0);
    check(found == 1'b0 && next_hop == 8'd0, "R1 reset result", int'(next_hop), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0 && found == 1'b0, "R1 after reset",
          int'(in_ready), 1);

    // empty table: root only, miss (R4 R6)
    lookup(32'hA000_0000, 0, 0);

    // routes: 10->7, 1011->5, 10110001->9, 011 expanded to 0110/0111 ->3, 11->11
    wr_node(0, 0, 2, 1, 8, 0, 0);
    wr_node(1, 0, 0, 0, 3, 1, 7);
    wr_node(3, 4, 0, 0, 0, 1, 5);
    wr_node(4, 0, 5, 0, 0, 0, 0);
    wr_node(5, 0, 0, 0, 0, 1, 9);
    wr_node(2, 0, 0, 6, 7, 0, 0);
    wr_node(6, 0, 0, 0, 0, 1, 3);
    wr_node(7, 0, 0, 0, 0, 1, 3);
    // chain of all-ones to depth 16: node 7+d at depth d
    for (int d = 1; d <= 16; d++)
      wr_node(7 + d, 0, 0, 0, (d < 16) ? 8 + d : 0, (d == 1) || (d == 16),
              (d == 16) ? 42 : 11);

    lookup(32'h8000_0000, 0, 0);        // R5 /2 route
    lookup(32'hB123_4567, 0, 0);        // R5 deepest /8 wins
    lookup(32'hB000_0000, 0, 0);        // R4 null at node without hop, keep /4
    lookup(32'h6000_0000, 0, 0);        // R5 expanded copy 0110
    lookup(32'h7FFF_0000, 0, 0);        // R5 expanded copy 0111
    lookup(32'h4000_0000, 0, 0);        // R6 miss after a hit
    lookup(32'h0000_0000, 0, 0);        // R4 null at root
    lookup(32'hFFFF_FFFF, 0, 0);        // R8 full depth, 17 visits
    lookup(32'hFFFF_FFFE, 0, 0);        // R8 null at depth 15
    lookup(32'hB100_0000, 1, 32'h4000_0000); // R2 busy requests ignored
    lookup(32'h4000_0000, 1, 32'hFFFF_FFFF); // R2
    wr_node(1, 0, 0, 0, 3, 1, 12);      // R10 rewrite
    lookup(32'h8000_0000, 0, 0);
    lookup(32'hBFFF_FFFF, 0, 0);        // R3 slice order

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule